// File: doc/BRIEF.md
# Infrared pulse run-length sampler

The block takes the output of a demodulating infrared receiver, samples it on a tick derived from the base clock, and turns the sampled waveform into a stream of bytes. Each byte gives a line level and the number of consecutive samples spent at that level. The stream is meant to be pushed into a receive FIFO that software drains and decodes. A packet opens once the line has been active for long enough, and closes after a long quiet period. The block marks the close with a one-cycle end strobe.

The raw line passes through a two-flop synchroniser. It can be inverted so that an active-low receiver reads as active pulses. A glitch filter then absorbs level changes that do not persist for a programmable number of samples. A level change that does persist is delayed by the same number of samples on every edge, so run lengths are preserved. Runs longer than one byte can hold are split into several bytes that carry the same level. All configuration inputs are expected to stay constant while the block is out of reset.

Top module: `ir_runlen_sampler`

## Requirements
- R1: One sample is taken every 64 base clocks when `sample_slow` is 0, and every 128 base clocks when it is 1.
- R2: Each output byte holds the level in bit 7 (1 = active pulse, 0 = space) and the run length minus one, in samples, in bits 6:0. A byte is emitted only when a run ends or a chunk fills, and at most one byte is emitted per sample.
- R3: When `rx_invert` is 1, a low line is treated as active and a high line as space.
- R4: A level change is accepted only after the new level has been seen on F consecutive samples, where F is `filter_len` and a value of 0 acts as 1. A change lasting fewer samples is absorbed into the surrounding run. An accepted change shifts both edges of a pulse equally, so the lengths of accepted runs are kept.
- R5: A packet starts on the sample at which the filtered active run reaches T = `active_len_m1` + 1 samples. The first byte counts the run from that sample onward.
- R6: When `active_x128` is 1, the start threshold becomes T = (`active_len_m1` + 1) * 128 samples.
- R7: A run of more than 128 samples is emitted as a sequence of bytes 0xFF (active) or 0x7F (space), each covering 128 samples, followed by one byte for the remainder.
- R8: Inside a packet, a space that lasts (`idle_units` + 1) * 128 samples ends the packet. The last space byte, 0x7F, is emitted in the same cycle as a single-cycle `packet_end` pulse, and `packet_end` is high exactly once per packet.
- R9: No byte is emitted while the block waits for a packet start, whether before the first packet or after a packet has ended.
- R10: After reset, `run_valid` and `packet_end` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Raw demodulated receiver line (asynchronous) |
| rx_invert | input | 1 | 1 = treat a low line as active |
| sample_slow | input | 1 | Sample divider select: 0 = /64, 1 = /128 |
| filter_len | input | 6 | Glitch filter length in samples (0 acts as 1) |
| idle_units | input | 8 | Idle timeout N; the packet ends after (N+1)*128 space samples |
| active_len_m1 | input | 7 | Packet start threshold minus one, in samples |
| active_x128 | input | 1 | Multiply the start threshold by 128 |
| run_valid | output | 1 | One-cycle strobe qualifying `run_byte` |
| run_byte | output | 8 | Level in bit 7, run length minus one in bits 6:0 |
| packet_end | output | 1 | One-cycle strobe at the idle timeout |

## Verification
The assertions assume that the configuration inputs do not change while the block is out of reset, and that the divider is at least two clocks. They also assume that the filtered level can only move on a sample strobe. The stimulus applies each configuration only while reset is held, and re-applies reset before every scenario. It holds the line for whole multiples of the selected divider, so every level segment covers a known number of samples whatever the tick phase. Each packet is always closed by a space longer than the idle timeout. This means the expected bytes, and the single end strobe that comes with the last of them, can be derived from the segment lengths alone.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

    localparam int RUN_W      = 7;
    localparam int FILT_W     = 6;
    localparam int IDLE_W     = 8;
    localparam int ACT_W      = 7;
    localparam int SCALE      = 128;
    localparam int SCALE_SH   = $clog2(SCALE);
    localparam int ACT_CNT_W  = ACT_W + SCALE_SH + 1;
    localparam int IDLE_CNT_W = IDLE_W + SCALE_SH + 1;

    typedef enum logic {
        PH_WAIT   = 1'b0,
        PH_PACKET = 1'b1
    } phase_e;

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] len_m1;
    } run_byte_t;

    typedef struct packed {
        logic              invert;
        logic              slow;
        logic [FILT_W-1:0] filt;
        logic [IDLE_W-1:0] idle;
        logic [ACT_W-1:0]  act_m1;
        logic              act_x128;
    } cfg_t;

    function automatic logic [ACT_CNT_W-1:0] active_target(
        input logic [ACT_W-1:0] m1,
        input logic             x128
    );
        logic [ACT_CNT_W-1:0] base;
        base = ACT_CNT_W'(m1) + 1'b1;
        return x128 ? (base << SCALE_SH) : base;
    endfunction

    function automatic logic [IDLE_CNT_W-1:0] idle_target(
        input logic [IDLE_W-1:0] n
    );
        logic [IDLE_CNT_W-1:0] base;
        base = IDLE_CNT_W'(n) + 1'b1;
        return base << SCALE_SH;
    endfunction

    function automatic logic [FILT_W-1:0] filt_need(
        input logic [FILT_W-1:0] f
    );
        return (f == '0) ? FILT_W'(1) : f;
    endfunction

endpackage

// File: rtl/ir_rl_tick.sv
module ir_rl_tick #(
    parameter int DIV_FAST = 64,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    output logic tick
);
    localparam int CW = $clog2(DIV_SLOW);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1

endmodule

// File: rtl/ir_rl_filter.sv
module ir_rl_filter
    import ir_rl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raw,
    input  logic              invert,
    input  logic              tick,
    input  logic [FILT_W-1:0] filt,
    output logic              lvl_q,
    output logic              stb_q
);
    logic [1:0]        sync_q;
    logic              smp;
    logic [FILT_W-1:0] need;
    logic [FILT_W-1:0] diff_q;
    logic              reach;

    assign smp   = sync_q[1] ^ invert;
    assign need  = filt_need(filt);
    assign reach = ({1'b0, diff_q} + 1'b1) >= {1'b0, need};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            lvl_q  <= 1'b0;
            diff_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw};
            stb_q  <= tick;
            if (tick) begin
                if (smp == lvl_q) begin
                    diff_q <= '0;
                end else if (reach) begin
                    lvl_q  <= smp;
                    diff_q <= '0;
                end else begin
                    diff_q <= diff_q + 1'b1;
                end
            end
        end
    end

    AST_FLT_STEADY: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(lvl_q)); // R4

    AST_FLT_STROBE_SPACING: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q); // R1

endmodule

// File: rtl/ir_rl_encoder.sv
module ir_rl_encoder
    import ir_rl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  stb,
    input  logic                  lvl,
    input  logic [ACT_CNT_W-1:0]  act_goal,
    input  logic [IDLE_CNT_W-1:0] idle_goal,
    output logic                  out_valid,
    output logic [7:0]            out_byte,
    output logic                  pkt_end
);
    phase_e                phase_q;
    logic [ACT_CNT_W-1:0]  act_cnt_q;
    logic [IDLE_CNT_W-1:0] idle_cnt_q;
    logic                  run_lvl_q;
    logic [RUN_W-1:0]      run_len_q;
    logic                  ov_q;
    logic                  pe_q;
    run_byte_t             ob_q;

    assign out_valid = ov_q;
    assign out_byte  = ob_q;
    assign pkt_end   = pe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_WAIT;
            act_cnt_q  <= '0;
            idle_cnt_q <= '0;
            run_lvl_q  <= 1'b0;
            run_len_q  <= '0;
            ov_q       <= 1'b0;
            pe_q       <= 1'b0;
            ob_q       <= '0;
        end else begin
            ov_q <= 1'b0;
            pe_q <= 1'b0;
            if (stb) begin
                unique case (phase_q)
                    PH_WAIT: begin
                        if (lvl) begin
                            if ((act_cnt_q + 1'b1) >= act_goal) begin
                                phase_q    <= PH_PACKET;
                                run_lvl_q  <= 1'b1;
                                run_len_q  <= '0;
                                idle_cnt_q <= '0;
                                act_cnt_q  <= '0;
                            end else begin
                                act_cnt_q <= act_cnt_q + 1'b1;
                            end
                        end else begin
                            act_cnt_q <= '0;
                        end
                    end
                    PH_PACKET: begin
                        if (lvl != run_lvl_q) begin
                            ov_q      <= 1'b1;
                            ob_q      <= '{lvl: run_lvl_q, len_m1: run_len_q};
                            run_lvl_q <= lvl;
                            run_len_q <= '0;
                        end else if (!lvl && ((idle_cnt_q + 1'b1) >= idle_goal)) begin
                            ov_q      <= 1'b1;
                            pe_q      <= 1'b1;
                            ob_q      <= '{lvl: 1'b0, len_m1: run_len_q + 1'b1};
                            phase_q   <= PH_WAIT;
                            act_cnt_q <= '0;
                            run_len_q <= '0;
                        end else if (&run_len_q) begin
                            ov_q      <= 1'b1;
                            ob_q      <= '{lvl: run_lvl_q, len_m1: run_len_q};
                            run_len_q <= '0;
                        end else begin
                            run_len_q <= run_len_q + 1'b1;
                        end
                        idle_cnt_q <= lvl ? '0 : idle_cnt_q + 1'b1;
                    end
                    default: phase_q <= PH_WAIT;
                endcase
            end
        end
    end

    AST_END_CARRIES_BYTE: assert property (@(posedge clk) disable iff (rst)
        pe_q |-> (ov_q && ob_q == 8'h7F)); // R8

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pe_q |=> !pe_q); // R8

    AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAIT) |=> !ov_q); // R9

    AST_START_ON_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PACKET && $past(phase_q) == PH_WAIT) |-> $past(stb && lvl)); // R5

    AST_BYTE_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        ov_q |-> $past(stb)); // R2

endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler
    import ir_rl_pkg::*;
#(
    parameter int DIV_FAST = 64,
    parameter int DIV_SLOW = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ir_in,
    input  logic       rx_invert,
    input  logic       sample_slow,
    input  logic [5:0] filter_len,
    input  logic [7:0] idle_units,
    input  logic [6:0] active_len_m1,
    input  logic       active_x128,
    output logic       run_valid,
    output logic [7:0] run_byte,
    output logic       packet_end
);
    cfg_t                  cfg;
    logic                  tick;
    logic                  flt_lvl;
    logic                  flt_stb;
    logic [ACT_CNT_W-1:0]  act_goal;
    logic [IDLE_CNT_W-1:0] idle_goal;

    assign cfg = '{invert:   rx_invert,
                   slow:     sample_slow,
                   filt:     filter_len,
                   idle:     idle_units,
                   act_m1:   active_len_m1,
                   act_x128: active_x128};

    assign act_goal  = active_target(cfg.act_m1, cfg.act_x128);
    assign idle_goal = idle_target(cfg.idle);

    ir_rl_tick #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .slow (cfg.slow),
        .tick (tick)
    );

    ir_rl_filter u_filter (
        .clk    (clk),
        .rst    (rst),
        .raw    (ir_in),
        .invert (cfg.invert),
        .tick   (tick),
        .filt   (cfg.filt),
        .lvl_q  (flt_lvl),
        .stb_q  (flt_stb)
    );

    ir_rl_encoder u_enc (
        .clk       (clk),
        .rst       (rst),
        .stb       (flt_stb),
        .lvl       (flt_lvl),
        .act_goal  (act_goal),
        .idle_goal (idle_goal),
        .out_valid (run_valid),
        .out_byte  (run_byte),
        .pkt_end   (packet_end)
    );

endmodule

// File: tb/ir_runlen_sampler_test.sv
module ir_runlen_sampler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ir_in = 1'b0;
    logic       rx_invert = 1'b0;
    logic       sample_slow = 1'b0;
    logic [5:0] filter_len = '0;
    logic [7:0] idle_units = '0;
    logic [6:0] active_len_m1 = '0;
    logic       active_x128 = 1'b0;
    logic       run_valid;
    logic [7:0] run_byte;
    logic       packet_end;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] cap [0:31];
    int cap_n = 0;
    int pe_cnt = 0;
    int pe_idx = -1;
    int pe_alone = 0;
    logic [7:0] exp_b [0:7];
    int exp_n = 0;

    always #2 clk = ~clk;

    ir_runlen_sampler uut (
        .clk           (clk),
        .rst           (rst),
        .ir_in         (ir_in),
        .rx_invert     (rx_invert),
        .sample_slow   (sample_slow),
        .filter_len    (filter_len),
        .idle_units    (idle_units),
        .active_len_m1 (active_len_m1),
        .active_x128   (active_x128),
        .run_valid     (run_valid),
        .run_byte      (run_byte),
        .packet_end    (packet_end)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (run_valid) begin
                if (cap_n < 32) cap[cap_n] = run_byte;
                if (packet_end) pe_idx = cap_n;
                cap_n++;
            end
            if (packet_end) begin
                pe_cnt++;
                if (!run_valid) pe_alone++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input bit inv, input bit slow, input int filt,
                         input int idle, input int actm1, input bit x128);
        @(negedge clk);
        rst           = 1'b1;
        rx_invert     = inv;
        sample_slow   = slow;
        filter_len    = 6'(filt);
        idle_units    = 8'(idle);
        active_len_m1 = 7'(actm1);
        active_x128   = x128;
        ir_in         = inv;
        repeat (4) @(negedge clk);
        cap_n    = 0;
        pe_cnt   = 0;
        pe_idx   = -1;
        pe_alone = 0;
        rst      = 1'b0;
    endtask

    task automatic hold(input bit active, input int samples);
        ir_in = active ^ rx_invert;
        repeat (samples * (sample_slow ? 128 : 64)) @(negedge clk);
    endtask

    task automatic compare(input string tag, input int pe_exp);
        chk({tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            chk({tag, " byte"}, cap[i], exp_b[i]);
        chk({tag, " end strobes"}, pe_cnt, pe_exp);
        if (pe_exp > 0) begin
            chk({tag, " end with last byte"}, pe_idx, exp_n - 1);
            chk({tag, " end without byte"}, pe_alone, 0);
        end
    endtask

    task automatic t_reset_state();
        setup(1'b0, 1'b0, 0, 0, 3, 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 run_valid after reset", run_valid, 0);
        chk("R10 packet_end after reset", packet_end, 0);
    endtask

    task automatic t_basic();
        setup(1'b0, 1'b0, 0, 0, 3, 1'b0);
        hold(1'b0, 5);
        hold(1'b1, 10);
        hold(1'b0, 5);
        hold(1'b1, 7);
        hold(1'b0, 200);
        exp_b[0] = 8'h86; exp_b[1] = 8'h04; exp_b[2] = 8'h86; exp_b[3] = 8'h7F;
        exp_n = 4;
        compare("R1 R2 R5 R8 R9 basic", 1);
    endtask

    task automatic t_split();
        setup(1'b0, 1'b0, 0, 0, 3, 1'b0);
        hold(1'b1, 300);
        hold(1'b0, 140);
        exp_b[0] = 8'hFF; exp_b[1] = 8'hFF; exp_b[2] = 8'hA8; exp_b[3] = 8'h7F;
        exp_n = 4;
        compare("R7 long run split", 1);
    endtask

    task automatic t_glitch();
        setup(1'b0, 1'b0, 4, 0, 3, 1'b0);
        hold(1'b0, 3);
        hold(1'b1, 20);
        hold(1'b0, 6);
        hold(1'b1, 2);
        hold(1'b0, 6);
        hold(1'b1, 8);
        hold(1'b0, 140);
        exp_b[0] = 8'h90; exp_b[1] = 8'h0D; exp_b[2] = 8'h87; exp_b[3] = 8'h7F;
        exp_n = 4;
        compare("R4 glitch filter", 1);
    endtask

    task automatic t_invert();
        setup(1'b1, 1'b0, 0, 0, 3, 1'b0);
        hold(1'b0, 5);
        hold(1'b1, 6);
        hold(1'b0, 3);
        hold(1'b1, 5);
        hold(1'b0, 140);
        exp_b[0] = 8'h82; exp_b[1] = 8'h02; exp_b[2] = 8'h84; exp_b[3] = 8'h7F;
        exp_n = 4;
        compare("R3 inverted input", 1);
    endtask

    task automatic t_gate();
        setup(1'b0, 1'b0, 0, 0, 7, 1'b0);
        for (int k = 0; k < 3; k++) begin
            hold(1'b1, 5);
            hold(1'b0, 5);
        end
        chk("R9 R5 no bytes below threshold", cap_n, 0);
        chk("R9 no end strobe below threshold", pe_cnt, 0);
        hold(1'b1, 8);
        hold(1'b0, 140);
        exp_b[0] = 8'h80; exp_b[1] = 8'h7F;
        exp_n = 2;
        compare("R5 threshold met exactly", 1);
    endtask

    task automatic t_scale();
        setup(1'b0, 1'b0, 0, 0, 0, 1'b1);
        hold(1'b1, 100);
        hold(1'b0, 10);
        chk("R6 scaled threshold not met", cap_n, 0);
        hold(1'b1, 130);
        hold(1'b0, 140);
        exp_b[0] = 8'h82; exp_b[1] = 8'h7F;
        exp_n = 2;
        compare("R6 scaled threshold", 1);
    endtask

    task automatic t_slow_idle();
        setup(1'b0, 1'b1, 0, 1, 3, 1'b0);
        hold(1'b0, 5);
        hold(1'b1, 6);
        hold(1'b0, 260);
        exp_b[0] = 8'h82; exp_b[1] = 8'h7F; exp_b[2] = 8'h7F;
        exp_n = 3;
        compare("R1 R8 slow divider two idle units", 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R10 watchdog: actual=timeout expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_basic();
        t_split();
        t_glitch();
        t_invert();
        t_gate();
        t_scale();
        t_slow_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule